// File: doc/BRIEF.md
# Broadcast-Grouped Scan Forest with XOR Response Compaction

This block wraps a small combinational core whose state flip-flops are arranged as several scan trees rather than one serial chain. Each tree has its own scan-in pin and is built from levels; every level holds a group of flip-flops that all load the same bit on a shift, and only the first member of each group passes its value to the group one level further down. A complete test vector therefore needs only as many shift cycles as the trees have levels. The bit for the deepest level goes in first, and the bit for the top level goes in last.

Responses are observed through XOR trees. Each XOR tree combines one leaf flip-flop from every scan tree, so no XOR tree mixes two leaves of the same scan tree. In test mode the XOR results replace the core's primary outputs on the shared output pins. A built-in sequencer runs a programmed number of vectors. For each vector it runs the shift phase and then one capture cycle. Unloading of each response overlaps with loading of the next vector, and the sequencer ends with one final unload pass. The offline grouping analysis and pattern generation are not part of this block; the topology is fixed by parameters.

Top module: `scan_forest_xor`

## Requirements
- R1: After reset every scan flip-flop holds 0, and busy, done, shift_req and capture are all low. With test_mode high, data_out is then all zeros.
- R2: On a shift edge, every flip-flop in level 0 of tree t loads scan_in[t]. Every flip-flop in level l>0 loads member 0 of level l-1 of the same tree. So after any shift, all members of one group hold equal values.
- R3: Feeding LEVELS shift bits into a tree places the first bit fed in the deepest level and the last bit fed in level 0.
- R4: On an edge without shifting, flip-flop i takes q[i] ^ (q[(i+1)%N] & q[(i+2)%N]) ^ func_in[i%NPI]. Flop index i is (t*LEVELS+l)*GROUP+g, and N is the flip-flop count.
- R5: With test_mode low, data_out[k] = q[k%N] ^ q[(k+3)%N] ^ func_in[k%NPI].
- R6: With test_mode high, data_out[k] is the XOR over all trees of one leaf. For k<GROUP the leaf is member k of the deepest level. For k>=GROUP, with j=k-GROUP, the leaf is member 1+j%(GROUP-1) of level j/(GROUP-1).
- R7: Starting a run with num_vec=V>0 gives V repeats of (LEVELS cycles with shift_req high, then 1 cycle with capture high), then LEVELS unload shift cycles with shift_req low. busy is high for exactly V*(LEVELS+1)+LEVELS cycles, and done is high in the cycle after busy falls.
- R8: A start with num_vec equal to 0 is ignored, and so is a start while busy.
- R9: While busy, scan_enable has no effect: the sequencer alone picks shift or capture. While idle, scan_enable high selects shift.
- R10: done stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_enable | input | 1 | Manual shift select while idle |
| test_mode | input | 1 | Selects XOR compaction results onto data_out |
| scan_in | input | NTREES | One scan-in bit per tree |
| func_in | input | NPI | Primary inputs to the core |
| start | input | 1 | Starts a sequenced run |
| num_vec | input | VW | Number of vectors in the run |
| data_out | output | NXOR | Core outputs or XOR results |
| shift_req | output | 1 | Asks for scan_in data this cycle |
| capture | output | 1 | Capture cycle of the sequencer |
| busy | output | 1 | Sequencer running |
| done | output | 1 | Run finished |

## Verification
The bench builds the block with three trees of three levels and groups of two, giving four XOR outputs. Two of these XOR outputs watch the deepest level and two watch the non-chaining members of the upper levels. This makes both kinds of leaf visible, and every XOR output combines leaves from three distinct trees. A behavioural model of the grouping and the core predicts every output on every cycle. That covers runs of one and three vectors, where overlapped unload can be checked against the cycle count, and a run driven with stray scan_enable and start pulses.

// File: rtl/scan_forest_xor.sv
module scan_forest_xor #(
  parameter int NTREES = 3,
  parameter int LEVELS = 3,
  parameter int GROUP  = 2,
  parameter int NPI    = 4,
  parameter int VW     = 8,
  localparam int N     = NTREES * LEVELS * GROUP,
  localparam int NXOR  = GROUP + (LEVELS - 1) * (GROUP - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_enable,
  input  logic              test_mode,
  input  logic [NTREES-1:0] scan_in,
  input  logic [NPI-1:0]    func_in,
  input  logic              start,
  input  logic [VW-1:0]     num_vec,
  output logic [NXOR-1:0]   data_out,
  output logic              shift_req,
  output logic              capture,
  output logic              busy,
  output logic              done
);

  localparam int CW  = $clog2(LEVELS + 1);
  localparam int GM1 = (GROUP > 1) ? GROUP - 1 : 1;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_CAPT, S_UNLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [VW-1:0] vleft;
  logic          done_q;
  logic [N-1:0]  q, q_shift, d_core;
  logic [NXOR-1:0] po_core, po_xor;
  logic          do_shift;

  assign busy      = (st != S_IDLE);
  assign shift_req = (st == S_SHIFT);
  assign capture   = (st == S_CAPT);
  assign done      = done_q;
  assign do_shift  = busy ? (st == S_SHIFT || st == S_UNLD) : scan_enable;
  assign data_out  = test_mode ? po_xor : po_core;

  genvar gi, gt, gl, gg, gk;
  generate
    for (gi = 0; gi < N; gi++) begin : g_core
      assign d_core[gi] = q[gi] ^ (q[(gi+1)%N] & q[(gi+2)%N]) ^ func_in[gi%NPI];
    end
    for (gk = 0; gk < NXOR; gk++) begin : g_po
      assign po_core[gk] = q[gk%N] ^ q[(gk+3)%N] ^ func_in[gk%NPI];
    end
    for (gt = 0; gt < NTREES; gt++) begin : g_tree
      for (gl = 0; gl < LEVELS; gl++) begin : g_lvl
        for (gg = 0; gg < GROUP; gg++) begin : g_mem
          localparam int I = (gt*LEVELS + gl)*GROUP + gg;
          if (gl == 0) begin : g_root
            assign q_shift[I] = scan_in[gt];
          end else begin : g_inner
            assign q_shift[I] = q[(gt*LEVELS + gl - 1)*GROUP];
          end
          if (gg > 0) begin : g_chk
            a_r2_group_equal: assert property (@(posedge clk) disable iff (!rst_n)
              $past(do_shift) |-> q[I] == q[(gt*LEVELS + gl)*GROUP]);
          end
        end
      end
    end
    for (gk = 0; gk < NXOR; gk++) begin : g_xor
      localparam int LV = (gk < GROUP) ? LEVELS - 1 : (gk - GROUP) / GM1;
      localparam int MB = (gk < GROUP) ? gk : 1 + (gk - GROUP) % GM1;
      logic [NTREES-1:0] taps;
      for (gt = 0; gt < NTREES; gt++) begin : g_tap
        assign taps[gt] = q[(gt*LEVELS + LV)*GROUP + MB];
      end
      assign po_xor[gk] = ^taps;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= do_shift ? q_shift : d_core;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; vleft <= '0; done_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start && num_vec != '0) begin
          st <= S_SHIFT; cnt <= '0; vleft <= num_vec; done_q <= 1'b0;
        end
        S_SHIFT: if (cnt == CW'(LEVELS - 1)) begin
          st <= S_CAPT; cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_CAPT: begin
          st <= (vleft == VW'(1)) ? S_UNLD : S_SHIFT;
          vleft <= vleft - 1'b1;
          cnt <= '0;
        end
        default: if (cnt == CW'(LEVELS - 1)) begin
          st <= S_IDLE; cnt <= '0; done_q <= 1'b1;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  logic [CW:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_len <= '0;
    else if (shift_req) run_len <= run_len + 1'b1;
    else                run_len <= '0;
  end

  a_r7_capture_after_levels: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> run_len == (CW+1)'(LEVELS));
  a_r7_shift_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    shift_req |-> run_len < (CW+1)'(LEVELS));
  a_r7_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r10_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(start && num_vec != '0)) |=> done);
  a_r8_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && num_vec == '0) |=> !busy);

endmodule

// File: tb/tb_scan_forest_xor.sv
module tb_scan_forest_xor;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 3, L = 3, G = 2, NPI = 4, VW = 8;
  localparam int N = NT*L*G;
  localparam int NX = G + (L-1)*(G-1);

  logic clk = 0, rst_n = 0, scan_enable = 0, test_mode = 0, start = 0;
  logic [NT-1:0] scan_in = '0;
  logic [NPI-1:0] func_in = '0;
  logic [VW-1:0] num_vec = '0;
  logic [NX-1:0] data_out;
  logic shift_req, capture, busy, done;

  int checks = 0, fails = 0, nbusy = 0;
  logic [N-1:0] mq = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_forest_xor #(.NTREES(NT), .LEVELS(L), .GROUP(G), .NPI(NPI), .VW(VW)) dut (
    .clk(clk), .rst_n(rst_n), .scan_enable(scan_enable), .test_mode(test_mode),
    .scan_in(scan_in), .func_in(func_in), .start(start), .num_vec(num_vec),
    .data_out(data_out), .shift_req(shift_req), .capture(capture),
    .busy(busy), .done(done));

  function automatic int idx(int t, int l, int g);
    return (t*L + l)*G + g;
  endfunction

  function automatic logic [NX-1:0] exp_out(logic tm, logic [NPI-1:0] pi);
    logic [NX-1:0] r;
    for (int k = 0; k < NX; k++) begin
      if (tm) begin
        int lv = (k < G) ? L-1 : (k-G)/(G-1);
        int mb = (k < G) ? k : 1 + (k-G)%(G-1);
        logic x = 1'b0;
        for (int t = 0; t < NT; t++) x ^= mq[idx(t, lv, mb)];
        r[k] = x;
      end else r[k] = mq[k%N] ^ mq[(k+3)%N] ^ pi[k%NPI];
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [NT-1:0] si, input logic [NPI-1:0] pi,
                     input logic se, input logic st, input logic tm,
                     input logic [VW-1:0] nv, input bit shift, input string tag);
    logic [N-1:0] nq;
    scan_in = si; func_in = pi; scan_enable = se; start = st; test_mode = tm; num_vec = nv;
    #1;
    check(tag, 32'(data_out), 32'(exp_out(tm, pi)));
    if (busy) nbusy++;
    @(posedge clk);
    for (int t = 0; t < NT; t++)
      for (int l = 0; l < L; l++)
        for (int g = 0; g < G; g++) begin
          int i = idx(t, l, g);
          if (shift) nq[i] = (l == 0) ? si[t] : mq[idx(t, l-1, 0)];
          else nq[i] = mq[i] ^ (mq[(i+1)%N] & mq[(i+2)%N]) ^ pi[i%NPI];
        end
    mq = nq;
    @(negedge clk);
    start = 0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1;
    test_mode = 1; #1;
    check("R1 data_out", 32'(data_out), 0);
    check("R1 busy", 32'(busy), 0);
    check("R1 done", 32'(done), 0);
    check("R1 shift_req", 32'(shift_req), 0);
    check("R1 capture", 32'(capture), 0);
  endtask

  task automatic t_manual_shift;
    logic [NT-1:0] pat [L] = '{3'b101, 3'b011, 3'b110};
    for (int s = 0; s < L; s++) cyc(pat[s], 4'h0, 1, 0, 1, 0, 1, "R2 R6 shift");
    // first-fed bits now sit in the deepest level: XOR[0] is parity of pat[0]
    #1;
    check("R3 deepest", 32'(data_out[0]), 32'(^pat[0]));
    check("R3 top", 32'(data_out[G]), 32'(^pat[L-1]));
    for (int s = 0; s < 3; s++) cyc(NT'(s+1), 4'h0, 1, 0, 0, 0, 1, "R5 shift");
  endtask

  task automatic t_functional;
    for (int c = 0; c < 8; c++)
      cyc('0, NPI'($urandom), 0, 0, c[0], 0, 0, "R4 R5 functional");
  endtask

  task automatic run_seq(input int nv, input bit noise);
    nbusy = 0;
    cyc(NT'($urandom), NPI'($urandom), noise, 1, 1, VW'(nv), noise, "R7 start");
    for (int v = 0; v < nv; v++) begin
      for (int s = 0; s < L; s++) begin
        check("R7 shift_req", 32'(shift_req), 1);
        check("R7 busy", 32'(busy), 1);
        cyc(NT'($urandom), NPI'($urandom), noise, noise, 1, VW'(nv), 1, "R6 R9 load/unload");
      end
      check("R7 capture", 32'(capture), 1);
      cyc(NT'($urandom), NPI'($urandom), noise, noise, 1, VW'(nv), 0, "R4 R9 capture");
    end
    for (int u = 0; u < L; u++) begin
      check("R7 unload no req", 32'(shift_req), 0);
      cyc('0, NPI'($urandom), noise, 0, 1, VW'(nv), 1, "R6 final unload");
    end
    check("R7 busy end", 32'(busy), 0);
    check("R7 done", 32'(done), 1);
    check("R7 cycle count", 32'(nbusy), 32'(nv*(L+1)+L));
    for (int c = 0; c < 2; c++) cyc('0, NPI'($urandom), 0, 0, 0, 0, 0, "R5 idle");
    check("R10 done held", 32'(done), 1);
  endtask

  task automatic t_zero_vec;
    cyc('0, 4'h5, 0, 1, 1, 0, 0, "R8 zero start");
    check("R8 not busy", 32'(busy), 0);
    check("R8 done kept", 32'(done), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset;
    t_manual_shift;
    t_functional;
    run_seq(3, 0);
    t_zero_vec;
    run_seq(1, 0);
    run_seq(2, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule